// File: doc/BRIEF.md
# Quad Down-Counter Timer

This peripheral contains four independent down-counters. A small 32-bit register bus reaches them through an address, a write strobe, write data and combinational read data. Each counter has the following parts:

- a load register;
- a readable count;
- an 8-bit control word;
- a deferred reload register, which is copied into the count only when the count next passes zero.

The control word selects:

- enable;
- a 16-bit or 32-bit count width;
- a clock prescale of 1, 16 or 256;
- one of three underflow behaviours: wrap to all ones, reload from the deferred register, or stop at zero.

Every underflow sets a per-channel bit in a shared raw status register. That bit can be masked, is cleared by writing a one, and feeds a single combined interrupt line.

Each channel is controlled by a three-state machine. The states are IDLE (not counting), RUN (counting) and DONE (a one-shot channel has expired). The transitions are:

- START (IDLE→RUN): the enable bit is seen set.
- HALT (RUN→IDLE or DONE→IDLE): the enable bit is seen clear.
- EXPIRE (RUN→DONE): a one-shot underflow.
- REARM (DONE→RUN): a load write while enabled.

State changes follow the registered control word, so a change of enable takes effect one cycle after it is written. Software that wants an up-count subtracts the count it reads from the value it loaded.

Top module: `tmr_quad`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Address map:
  - Shared registers: mask at 0x00 (read/write), raw status at 0x04, masked status at 0x08, and write-one-to-clear at 0x0C (reads 0).
  - Channel n (0..3) starts at 0x10+0x10·n, with load at +0x0, count at +0x4, control at +0x8 and deferred reload at +0xC.
  - Load, control, reload and mask read back the value written.
- R3: A load write sets the count and the deferred reload to the written value, and restarts the prescale phase.
- R4: The count falls by one per prescaled tick while control bit 7 is set. After a control write that clears bit 7, at most one further decrement occurs, and then the count holds.
- R5: Control bits 3:2 set the tick rate: 00 gives a tick every cycle, 01 every 16 cycles, and 10 (or 11) every 256 cycles, counted from the load.
- R6: With bit 0 clear and bit 6 set, an underflow (a tick at count 0) reloads the count from the deferred register. A write to the deferred register leaves the current count untouched.
- R7: With bits 6 and 0 both clear, an underflow wraps the count to all ones of the width. Bit 1 selects a 32-bit width; when bit 1 is clear, only the low 16 bits count and are read.
- R8: With bit 0 set, the first underflow leaves the count at 0 in DONE. The status bit is raised once, and no further underflow occurs until a reload.
- R9: Raw status bit n is set by an underflow of channel n. Writing 1 to bit n at 0x0C clears it, but a simultaneous underflow wins.
- R10: Masked status equals raw AND mask, and `irq` is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | OR of masked status bits |

## Verification
The assertions check the status logic and the one-shot states on every cycle. An underflow is always followed by its raw bit. A clear without a competing underflow leaves the bit low. A channel in DONE holds a zero count and never underflows.

Other behaviours only show in the bench's scenarios:
- the decrement timing against each prescale setting;
- the choice between reload, wrap and stop;
- the deferred-reload rule;
- 16-bit truncation;
- address decode.

// File: rtl/tmr_quad_pkg.sv
package tmr_quad_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_RUN, CH_DONE} ch_state_e;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] spare;
        logic [1:0] psc;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam logic [1:0] W_MASK = 2'd0;
    localparam logic [1:0] W_RAW  = 2'd1;
    localparam logic [1:0] W_MIS  = 2'd2;
    localparam logic [1:0] W_CLR  = 2'd3;
    localparam logic [1:0] W_LD   = 2'd0;
    localparam logic [1:0] W_VAL  = 2'd1;
    localparam logic [1:0] W_CTRL = 2'd2;
    localparam logic [1:0] W_BG   = 2'd3;
endpackage

// File: rtl/tmr_quad_chan.sv
module tmr_quad_chan
    import tmr_quad_pkg::*;
#(
    parameter int DW      = 32,
    parameter int PSC_W   = 8,
    parameter int PSC_MID = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          ctrl_we,
    input  logic          bg_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] val_o,
    output logic [DW-1:0] ld_o,
    output logic [DW-1:0] bg_o,
    output logic [7:0]    ctrl_o,
    output logic          uf_o,
    output logic          done_o
);
    localparam int HALF = DW / 2;
    localparam logic [PSC_W-1:0] LIM_MID = PSC_W'((1 << PSC_MID) - 1);

    ctrl_t            ctrl_q;
    logic [DW-1:0]    ld_q, bg_q, cnt_q, eff, bg_eff;
    logic [PSC_W-1:0] psc_q, psc_lim;
    ch_state_e        st_q, st_d;
    logic             running, tick;

    assign eff    = ctrl_q.wide ? cnt_q : {{HALF{1'b0}}, cnt_q[HALF-1:0]};
    assign bg_eff = ctrl_q.wide ? bg_q  : {{HALF{1'b0}}, bg_q[HALF-1:0]};

    always_comb begin
        unique case (ctrl_q.psc)
            2'b00:   psc_lim = '0;
            2'b01:   psc_lim = LIM_MID;
            default: psc_lim = '1;
        endcase
    end

    assign running = (st_q == CH_RUN) && ctrl_q.en;
    assign tick    = running && (psc_q == psc_lim);
    assign uf_o    = tick && (eff == '0) && !ld_we;
    assign done_o  = (st_q == CH_DONE);

    // next-state: START, HALT, EXPIRE, REARM
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (ctrl_q.en) st_d = CH_RUN;
            CH_RUN: begin
                if (!ctrl_q.en)                   st_d = CH_IDLE;
                else if (uf_o && ctrl_q.oneshot)  st_d = CH_DONE;
            end
            CH_DONE: begin
                if (!ctrl_q.en)  st_d = CH_IDLE;
                else if (ld_we)  st_d = CH_RUN;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ld_q   <= '0;
            bg_q   <= '0;
            cnt_q  <= '0;
            psc_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(wdata[7:0]);
            if (ld_we) begin
                ld_q  <= wdata;
                bg_q  <= wdata;
                cnt_q <= wdata;
                psc_q <= '0;
            end else begin
                if (bg_we) bg_q <= wdata;
                if (running) psc_q <= (psc_q == psc_lim) ? '0 : psc_q + 1'b1;
                if (tick) begin
                    if (eff != '0)           cnt_q <= eff - 1'b1;
                    else if (ctrl_q.oneshot) cnt_q <= '0;
                    else if (ctrl_q.periodic) cnt_q <= bg_eff;
                    else if (ctrl_q.wide)    cnt_q <= '1;
                    else                     cnt_q <= {{HALF{1'b0}}, {HALF{1'b1}}};
                end
            end
        end
    end

    assign val_o  = eff;
    assign ld_o   = ld_q;
    assign bg_o   = bg_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_quad_irq.sv
module tmr_quad_irq #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [N_CH-1:0] wbits,
    input  logic [N_CH-1:0] uf,
    output logic [N_CH-1:0] mask_o,
    output logic [N_CH-1:0] raw_o,
    output logic [N_CH-1:0] mis_o,
    output logic            irq_o
);
    logic [N_CH-1:0] mask_q, raw_q, clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            raw_q <= (raw_q & ~clr_bits) | uf;
        end
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;
    assign mis_o  = raw_q & mask_q;
    assign irq_o  = |mis_o;
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
    import tmr_quad_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int PG_W = AW - 4;
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [PG_W-1:0] page;
    logic [1:0]      word;
    logic [DW-1:0]   val_a [N_CH];
    logic [DW-1:0]   ld_a  [N_CH];
    logic [DW-1:0]   bg_a  [N_CH];
    logic [7:0]      ctrl_a [N_CH];
    logic [N_CH-1:0] uf, done, mask, raw, mis;
    logic [N_CH*DW-1:0] val_flat;
    logic [CH_W-1:0] idx;

    assign page = addr[AW-1:4];
    assign word = addr[3:2];
    assign idx  = CH_W'(page - 1'b1);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (page == PG_W'(c + 1));
        tmr_quad_chan #(.DW(DW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_we  (sel && word == W_LD),
            .ctrl_we(sel && word == W_CTRL),
            .bg_we  (sel && word == W_BG),
            .wdata  (wr_data),
            .val_o  (val_a[c]),
            .ld_o   (ld_a[c]),
            .bg_o   (bg_a[c]),
            .ctrl_o (ctrl_a[c]),
            .uf_o   (uf[c]),
            .done_o (done[c])
        );
        assign val_flat[c*DW +: DW] = val_a[c];
    end

    tmr_quad_irq #(.N_CH(N_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_we(wr_en && page == '0 && word == W_MASK),
        .clr_we (wr_en && page == '0 && word == W_CLR),
        .wbits  (wr_data[N_CH-1:0]),
        .uf     (uf),
        .mask_o (mask),
        .raw_o  (raw),
        .mis_o  (mis),
        .irq_o  (irq)
    );

    always_comb begin
        rd_data = '0;
        if (page == '0) begin
            unique case (word)
                W_MASK:  rd_data = DW'(mask);
                W_RAW:   rd_data = DW'(raw);
                W_MIS:   rd_data = DW'(mis);
                default: rd_data = '0;
            endcase
        end else if (page <= PG_W'(N_CH)) begin
            unique case (word)
                W_LD:    rd_data = ld_a[idx];
                W_VAL:   rd_data = val_a[idx];
                W_CTRL:  rd_data = DW'(ctrl_a[idx]);
                default: rd_data = bg_a[idx];
            endcase
        end
    end
endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk #(
    parameter int N_CH = 4,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [AW-1:0]      addr,
    input logic [DW-1:0]      wr_data,
    input logic [N_CH-1:0]    uf,
    input logic [N_CH-1:0]    done,
    input logic [N_CH-1:0]    raw,
    input logic [N_CH*DW-1:0] val_flat
);
    for (genvar i = 0; i < N_CH; i++) begin : g_a
        AST_UF_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            uf[i] |=> raw[i]); // R9
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(12) && wr_data[i] && !uf[i]) |=> !raw[i]); // R9
        AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> (val_flat[i*DW +: DW] == '0)); // R8
        AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> !uf[i]); // R8
    end
endmodule

bind tmr_quad tmr_quad_chk #(.N_CH(N_CH), .DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .uf(uf), .done(done), .raw(raw), .val_flat(val_flat)
);

// File: tb/tmr_quad_tb.sv
module tmr_quad_tb_top;
    localparam int CLK_PERIOD = 20;

    typedef struct {
        bit          is_irq;
        logic [7:0]  a;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    item_t q[$];
    event  ev_s;

    tmr_quad dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares
    initial forever begin
        @(ev_s);
        #1;
        begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.a, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        it.is_irq = 0; it.a = a; it.exp = e; it.req = r;
        addr = a;
        q.push_back(it);
        -> ev_s;
        #2;
    endtask

    task automatic chk_irq(input logic e, input string r);
        item_t it;
        it.is_irq = 1; it.a = 8'h00; it.exp = {31'b0, e}; it.req = r;
        q.push_back(it);
        -> ev_s;
        #2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(8'h14, 0, "R1 count");
        chk(8'h04, 0, "R1 raw");
        chk(8'h18, 0, "R1 ctrl");
        chk_irq(0, "R1 irq");

        // ch0: enabled, periodic, 32-bit, /1
        wr(8'h18, 32'hC2);
        wr(8'h10, 5);
        chk(8'h14, 5, "R3 count after load");
        chk(8'h1C, 5, "R3 reload after load");
        chk(8'h10, 5, "R2 load readback");
        idle(3);
        chk(8'h14, 2, "R4 decrement");
        wr(8'h1C, 9);
        chk(8'h14, 1, "R6 reload write leaves count");
        idle(2);
        chk(8'h14, 9, "R6 periodic reload");
        chk(8'h04, 1, "R9 raw set");
        chk_irq(0, "R10 masked off");
        wr(8'h00, 1);
        chk_irq(1, "R10 irq");
        chk(8'h08, 1, "R10 masked status");
        chk(8'h00, 1, "R2 mask readback");
        wr(8'h0C, 1);
        chk(8'h04, 0, "R9 clear");
        chk_irq(0, "R10 irq after clear");
        wr(8'h18, 32'h42);
        chk(8'h14, 6, "R4 last decrement");
        idle(4);
        chk(8'h14, 6, "R4 halted");
        chk(8'h18, 32'h42, "R2 ctrl readback");

        // ch1: one-shot, 16-bit, /1
        wr(8'h28, 32'h81);
        wr(8'h20, 2);
        idle(3);
        chk(8'h24, 0, "R8 stopped at zero");
        chk(8'h04, 2, "R8 status raised");
        wr(8'h0C, 2);
        idle(5);
        chk(8'h04, 0, "R8 single event");
        chk(8'h24, 0, "R8 still zero");

        // ch2: free-running, 16-bit
        wr(8'h38, 32'h80);
        wr(8'h30, 32'h0001_0001);
        chk(8'h34, 1, "R7 16-bit truncation");
        chk(8'h30, 32'h0001_0001, "R2 ch2 load readback");
        idle(2);
        chk(8'h34, 32'h0000_FFFF, "R7 16-bit wrap");
        chk(8'h04, 4, "R9 raw ch2");
        chk_irq(0, "R10 unmasked channel");
        chk(8'h08, 0, "R10 masked excludes ch2");

        // ch3: free-running, 32-bit
        wr(8'h48, 32'h82);
        wr(8'h40, 0);
        chk(8'h44, 0, "R3 zero load");
        idle(1);
        chk(8'h44, 32'hFFFF_FFFF, "R7 32-bit wrap");
        chk(8'h04, 32'hC, "R9 raw ch2 ch3");

        // prescale /16 then /256 on ch3
        wr(8'h48, 32'h86);
        wr(8'h40, 3);
        idle(15);
        chk(8'h44, 3, "R5 /16 before tick");
        idle(1);
        chk(8'h44, 2, "R5 /16 tick");
        wr(8'h48, 32'h8A);
        wr(8'h40, 1);
        idle(255);
        chk(8'h44, 1, "R5 /256 before tick");
        idle(1);
        chk(8'h44, 0, "R5 /256 tick");
        chk(8'h4C, 1, "R2 ch3 reload readback");

        #5;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule